// File: doc/BRIEF.md
# Indexed-Extract Message Queue

A queue of 32-bit message words with a parameterised number of slots. Words enter at the tail through a push stream. Any stored word, at any position, can be taken out through a pull port that carries a slot index. The removed word is returned, and every younger word moves down one slot, so the queue stays packed from slot 0 upward. A slot that holds no message always contains the invalid marker `32'hFFFF_FFFF`. Unused slots never keep stale data.

The block keeps an occupancy count and drives a head peek. It also drives a 32-bit status word that carries full and empty flags together with the count. Both ports use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. Ready never depends on its own port's valid. `pull_ready` depends only on `pull_index` and the stored count. `push_ready` is high when a slot is free, or when a legal pull completes in the same cycle. A valid that meets a low ready is not held: that request is dropped, and a one-cycle error strobe is raised.

Top module: `msg_extract_queue`

## Requirements
- R1: After reset, `count` is 0, the status word shows empty, `peek` reads `32'hFFFF_FFFF`, and every slot read through `pull_data` reads `32'hFFFF_FFFF`.
- R2: A push with `push_valid && push_ready` stores `push_data` in slot `count` and increments `count` by one on that clock edge. `count` never exceeds DEPTH.
- R3: While `pull_index < count`, `pull_data` combinationally shows slot `pull_index`. A completed pull removes that word, moves slots index+1..count-1 down by one in the same order, and decrements `count`.
- R4: Every slot at a position `>= count` reads `32'hFFFF_FFFF` through `pull_data`, including a slot just vacated by a pull.
- R5: Status bit 31 is full (`count == DEPTH`) and bit 30 is empty (`count == 0`). Bits [CW-1:0] hold `count`, where CW = $clog2(DEPTH+1). All other bits are 0. The word is updated on the edge after every push or pull.
- R6: A push when the queue is full and no legal pull completes in the same cycle sees `push_ready` low. It leaves the contents unchanged, and `err` is high for exactly the next cycle.
- R7: A pull with `pull_index >= count` sees `pull_ready` low. It leaves the contents unchanged, and `err` is high for exactly the next cycle.
- R8: When a push and a legal pull complete in the same cycle, the pull is applied first. The pushed word lands in slot `count-1` and `count` stays the same. This is allowed even when the queue is full.
- R9: `peek` always shows slot 0 without removing it, and reads `32'hFFFF_FFFF` when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Push accepted this cycle |
| push_data | input | 32 | Word to append |
| pull_valid | input | 1 | Pull request |
| pull_ready | output | 1 | Pull index is in range |
| pull_index | input | $clog2(DEPTH) | Slot to extract |
| pull_data | output | 32 | Contents of slot `pull_index` |
| peek | output | 32 | Contents of slot 0 |
| count | output | $clog2(DEPTH+1) | Occupancy |
| status | output | 32 | {full, empty, zeros, count} |
| err | output | 1 | One-cycle strobe after a dropped request |

## Verification
The assertions check on every cycle that:
- the full and empty flags never appear together;
- the peek is the marker whenever the queue is empty;
- the count stays within bounds and moves by exactly one on a lone push;
- a full queue without a pull refuses pushes;
- a combined push and pull leaves the count unchanged;
- a dropped pull is followed by the error strobe.

Only the bench's reference model can show that words come back in the right order after extraction from the middle, and that every vacated slot really holds the marker. It can also show that the word pushed during a simultaneous pull lands behind the compacted entries. The bench checks this under directed fill, drain and middle-extraction sequences and under a long random mix.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef logic [31:0] word_t;
  localparam word_t MQ_EMPTY_WORD = 32'hFFFF_FFFF;
  localparam int    MQ_FULL_BIT   = 31;
  localparam int    MQ_EMPTY_BIT  = 30;
endpackage

// File: rtl/mq_occupancy.sv
module mq_occupancy #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          pull_valid,
  input  logic [IW-1:0] pull_index,
  output logic [CW-1:0] count,
  output logic [CW-1:0] write_slot,
  output logic          push_ready,
  output logic          pull_ready,
  output logic          push_fire,
  output logic          pull_fire,
  output logic          is_full,
  output logic          is_empty,
  output logic          err
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          err_q;

  // pull is legal only for an occupied slot
  assign pull_ready = CW'(pull_index) < count_q;
  assign pull_fire  = pull_valid && pull_ready;

  // pull is applied first, so a full queue accepts a push when a pull completes
  assign push_ready = (count_q != DEPTH_C) || pull_fire;
  assign push_fire  = push_valid && push_ready;

  assign write_slot = count_q - CW'(pull_fire);
  assign count_d    = write_slot + CW'(push_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      err_q   <= (push_valid && !push_ready) || (pull_valid && !pull_ready);
    end
  end

  assign count    = count_q;
  assign is_full  = count_q == DEPTH_C;
  assign is_empty = count_q == '0;
  assign err      = err_q;
endmodule

// File: rtl/mq_slot_array.sv
module mq_slot_array
  import mq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pull_fire,
  input  logic [IW-1:0] pull_index,
  input  logic          push_fire,
  input  logic [CW-1:0] write_slot,
  input  word_t         push_data,
  output word_t         pull_data,
  output word_t         head
);
  word_t slot_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    word_t upper;
    word_t shifted;
    word_t next;

    if (k == DEPTH - 1) begin : g_top
      assign upper = MQ_EMPTY_WORD;
    end else begin : g_mid
      assign upper = slot_q[k+1];
    end

    always_comb begin
      shifted = slot_q[k];
      if (pull_fire && (k >= int'(pull_index))) shifted = upper;
      next = shifted;
      if (push_fire && (write_slot == CW'(k))) next = push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[k] <= MQ_EMPTY_WORD;
      else        slot_q[k] <= next;
    end
  end

  always_comb begin
    pull_data = MQ_EMPTY_WORD;
    for (int k = 0; k < DEPTH; k++)
      if (int'(pull_index) == k) pull_data = slot_q[k];
  end

  assign head = slot_q[0];
endmodule

// File: rtl/mq_status_pack.sv
module mq_status_pack
  import mq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          is_full,
  input  logic          is_empty,
  output word_t         status
);
  always_comb begin
    status               = '0;
    status[CW-1:0]       = count;
    status[MQ_FULL_BIT]  = is_full;
    status[MQ_EMPTY_BIT] = is_empty;
  end
endmodule

// File: rtl/msg_extract_queue.sv
module msg_extract_queue
  import mq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [31:0]   push_data,
  input  logic          pull_valid,
  output logic          pull_ready,
  input  logic [IW-1:0] pull_index,
  output logic [31:0]   pull_data,
  output logic [31:0]   peek,
  output logic [CW-1:0] count,
  output logic [31:0]   status,
  output logic          err
);
  logic          push_fire;
  logic          pull_fire;
  logic          is_full;
  logic          is_empty;
  logic [CW-1:0] write_slot;

  mq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pull_valid (pull_valid),
    .pull_index (pull_index),
    .count      (count),
    .write_slot (write_slot),
    .push_ready (push_ready),
    .pull_ready (pull_ready),
    .push_fire  (push_fire),
    .pull_fire  (pull_fire),
    .is_full    (is_full),
    .is_empty   (is_empty),
    .err        (err)
  );

  mq_slot_array #(.DEPTH(DEPTH)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_fire  (pull_fire),
    .pull_index (pull_index),
    .push_fire  (push_fire),
    .write_slot (write_slot),
    .push_data  (push_data),
    .pull_data  (pull_data),
    .head       (peek)
  );

  mq_status_pack #(.DEPTH(DEPTH)) u_stat (
    .count    (count),
    .is_full  (is_full),
    .is_empty (is_empty),
    .status   (status)
  );
endmodule

// File: rtl/mq_checker.sv
module mq_checker #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          push_ready,
  input logic          pull_valid,
  input logic          pull_ready,
  input logic [IW-1:0] pull_index,
  input logic [31:0]   peek,
  input logic [CW-1:0] count,
  input logic [31:0]   status,
  input logic          err
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[31] && status[30])); // R5
  AST_EMPTY_PEEK: assert property (@(posedge clk) disable iff (!rst_n)
    status[30] |-> peek == 32'hFFFF_FFFF); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R2
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && !(pull_valid && pull_ready))
      |=> int'(count) == int'($past(count)) + 1); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH && !(pull_valid && pull_ready)) |-> !push_ready); // R6
  AST_BAD_PULL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_valid && !pull_ready) |=> err); // R7
  AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && pull_valid && pull_ready) |=> $stable(count)); // R8
endmodule

bind msg_extract_queue mq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .pull_valid (pull_valid),
  .pull_ready (pull_ready),
  .pull_index (pull_index),
  .peek       (peek),
  .count      (count),
  .status     (status),
  .err        (err)
);

// File: tb/msg_extract_queue_test.sv
module msg_extract_queue_test;
  localparam int D  = 8;
  localparam int IW = $clog2(D);
  localparam int CW = $clog2(D + 1);
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          push_valid = 0, pull_valid = 0;
  logic [31:0]   push_data = 0;
  logic [IW-1:0] pull_index = 0;
  logic          push_ready, pull_ready, err;
  logic [31:0]   pull_data, peek, status;
  logic [CW-1:0] count;

  int tests = 0, fails = 0;
  logic [31:0] model[$];
  logic exp_err = 0;
  logic done = 0;

  always #5 clk = ~clk;

  msg_extract_queue #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pull_valid(pull_valid), .pull_ready(pull_ready), .pull_index(pull_index),
    .pull_data(pull_data), .peek(peek), .count(count), .status(status), .err(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = 32'(model.size());
    if (model.size() == D) s[31] = 1'b1;
    if (model.size() == 0) s[30] = 1'b1;
    return s;
  endfunction

  // called at a negedge: checks registered state, drives, checks combinational outputs,
  // advances the model, then waits for the active edge
  task automatic step(bit pv, logic [31:0] pd, bit lv, int li);
    bit pull_ok, push_ok;
    chk("R2 count", 32'(count), 32'(model.size()));
    chk("R5 status", status, exp_status());
    chk("R9 peek", peek, model.size() > 0 ? model[0] : MARK);
    chk("R6/R7 err strobe", 32'(err), 32'(exp_err));
    push_valid = pv; push_data = pd; pull_valid = lv; pull_index = IW'(li);
    #1;
    pull_ok = li < model.size();
    push_ok = (model.size() < D) || (lv && pull_ok);
    chk(pull_ok ? "R3 pull_data" : "R4 vacant slot", pull_data, pull_ok ? model[li] : MARK);
    chk("R7 pull_ready", 32'(pull_ready), 32'(pull_ok));
    chk(lv && pull_ok ? "R8 push_ready" : "R6 push_ready", 32'(push_ready), 32'(push_ok));
    exp_err = (pv && !push_ok) || (lv && !pull_ok);
    if (lv && pull_ok) model.delete(li);
    if (pv && push_ok) model.push_back(pd);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, every slot reads the marker
    chk("R1 count", 32'(count), 0);
    chk("R1 status", status, 32'h4000_0000);
    chk("R1 peek", peek, MARK);
    for (int i = 0; i < D; i++) step(0, 0, 0, i);
    // R2: fill to full
    for (int i = 0; i < D; i++) step(1, 32'h100 + i, 0, 0);
    // R6: push while full is dropped
    step(1, 32'hDEAD_0001, 0, 0);
    step(0, 0, 0, 0);
    // R3: extract from the middle, then the tail
    step(0, 0, 1, 3);
    step(0, 0, 1, D - 2);
    // R4: read vacated slots
    for (int i = 0; i < D; i++) step(0, 0, 0, i);
    // R7: out-of-range pull
    step(0, 0, 1, D - 1);
    // R8: refill to full, then simultaneous pull and push
    step(1, 32'hA0, 0, 0);
    step(1, 32'hA1, 0, 0);
    step(1, 32'hB0, 1, 0);
    step(1, 32'hB1, 1, 5);
    // drain from the head
    for (int i = 0; i < D + 1; i++) step(0, 0, 1, 0);
    // R7 with a push at the same time as an illegal pull on an empty queue
    step(1, 32'hC0, 1, 4);
    // random mix
    for (int n = 0; n < 3000; n++)
      step(($urandom % 3) != 0, $urandom, ($urandom % 3) == 0, int'($urandom % D));
    step(0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule